// File: doc/BRIEF.md
# Stage-Controlled Banyan TDM Fabric

This block is an N-by-N switching fabric built as a butterfly of 2x2 exchange elements in log2 N stages, each stage holding N/2 elements. All elements of one stage share a single bar/cross setting, so a control word of only log2 N bits fixes the whole permutation applied in a slot. A free-running slot counter supplies that word. Each clock cycle is one time slot. Every input carries one data word and a valid flag, and each pair is forwarded to the output that the current permutation selects.

With the butterfly wiring used here, a crossed stage s swaps the two ports whose indices differ only in bit s. The output reached by input i in slot t is therefore i XOR t. The slot counter wraps every N cycles, so the sequence of permutations repeats with period N. Over any aligned frame of N slots, each input meets each output exactly once. A surrounding design uses the exported slot index and control word to know, in advance, which output every input will reach in any future slot.

Data and valid bits pass through the stages without registers and are captured once at the outputs. Results therefore appear one cycle after the slot in which they were presented.

Top module: `tdm_banyan_fabric`

## Requirements
- R1: While reset is asserted (rstN low), every outValid bit is 0, every outData bit is 0, and slotIdx is 0.
- R2: After reset, slotIdx rises by one on each rising clock edge and wraps from N-1 to 0, so the schedule repeats with period N.
- R3: ctrlWord equals slotIdx in every cycle. Bit s of ctrlWord set to 1 places every element of stage s in cross, and 0 places them in bar.
- R4: A word presented at input i (bits i*DATA_W upward of inData) in the cycle where slotIdx is t appears on output i XOR t on the following clock edge.
- R5: The valid bit travels with its word: outValid[i XOR t] one cycle later equals inValid[i]. An input that is not valid yields a 0 valid bit at its output.
- R6: Over each aligned frame of N slots starting at slot 0, every input-to-output pair is used exactly once.
- R7: In every slot the mapping is a permutation: no two inputs reach the same output, and the number of set outValid bits equals the number of set inValid bits one cycle earlier.
- R8: In slot 0 all stages are in bar, so each output carries the word from the input with the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | NUM_PORTS*DATA_W | Data words, port p in bits p*DATA_W upward |
| inValid | input | NUM_PORTS | Valid flag per input port |
| outData | output | NUM_PORTS*DATA_W | Registered routed data words |
| outValid | output | NUM_PORTS | Registered routed valid flags |
| ctrlWord | output | log2 NUM_PORTS | Per-stage bar/cross control applied to the present inputs |
| slotIdx | output | log2 NUM_PORTS | Current time-slot index |

## Verification
The slot index and control word describe the slot being applied to the inputs present now. They are checked in the same half-cycle as the stimulus, against a slot count the bench keeps on its own. Routed data and valid bits are due one rising edge after their inputs are presented. The bench drives on falling edges and compares outputs at the next falling edge with the inputs and slot it recorded one step before. The full-access and permutation checks use source tags carried in the low data bits. These checks are scored once the last slot of each frame has emerged from the output register.

// File: rtl/tdm_fabric_pkg.sv
package tdm_fabric_pkg;

  // Widest stage count the control struct can carry (up to 256 ports).
  localparam int MAX_STAGES = 8;

  // Control-to-datapath strobes for one slot.
  typedef struct packed {
    logic                  frameStart;  // slot 0 of the frame
    logic [MAX_STAGES-1:0] crossEn;     // per-stage cross enable, unused bits zero
  } slotCtrl_t;

endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_fabric_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  localparam int LOG2N = $clog2(NUM_PORTS)
) (
  input  logic             clk,
  input  logic             rstN,
  output slotCtrl_t        ctrl,
  output logic [LOG2N-1:0] slotIdx
);

  localparam logic [LOG2N-1:0] LAST_SLOT = LOG2N'(NUM_PORTS - 1);

  logic [LOG2N-1:0] slotCnt;
  logic             armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      armed   <= 1'b0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
      armed   <= 1'b1;
    end
  end

  always_comb begin
    ctrl            = '0;
    ctrl.crossEn[LOG2N-1:0] = slotCnt;
    ctrl.frameStart = (slotCnt == '0);
  end

  assign slotIdx = slotCnt;

  // R2: counting and wrap of the slot index
  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (slotCnt == LAST_SLOT) |=> (slotCnt == '0));

  a_r2_slot_step: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(slotCnt) != LAST_SLOT) |-> (slotCnt == $past(slotCnt) + 1'b1));

endmodule

// File: rtl/tdm_exchange_stage.sv
module tdm_exchange_stage #(
  parameter int NUM_PORTS = 16,
  parameter int DATA_W    = 8,
  parameter int PAIR_BIT  = 0
) (
  input  logic                        crossEn,
  input  logic [NUM_PORTS*DATA_W-1:0] inData,
  input  logic [NUM_PORTS-1:0]        inValid,
  output logic [NUM_PORTS*DATA_W-1:0] outData,
  output logic [NUM_PORTS-1:0]        outValid
);

  localparam int NUM_ELEMS = NUM_PORTS / 2;
  localparam int LOW_MASK  = (1 << PAIR_BIT) - 1;

  for (genvar e = 0; e < NUM_ELEMS; e++) begin : g_elem
    // Port pair that differs only in bit PAIR_BIT.
    localparam int LO = ((e >> PAIR_BIT) << (PAIR_BIT + 1)) | (e & LOW_MASK);
    localparam int HI = LO | (1 << PAIR_BIT);

    always_comb begin
      if (crossEn) begin
        outData[LO*DATA_W +: DATA_W] = inData[HI*DATA_W +: DATA_W];
        outData[HI*DATA_W +: DATA_W] = inData[LO*DATA_W +: DATA_W];
        outValid[LO]                 = inValid[HI];
        outValid[HI]                 = inValid[LO];
      end else begin
        outData[LO*DATA_W +: DATA_W] = inData[LO*DATA_W +: DATA_W];
        outData[HI*DATA_W +: DATA_W] = inData[HI*DATA_W +: DATA_W];
        outValid[LO]                 = inValid[LO];
        outValid[HI]                 = inValid[HI];
      end
    end
  end

endmodule

// File: rtl/tdm_banyan_datapath.sv
module tdm_banyan_datapath
  import tdm_fabric_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int DATA_W    = 8,
  localparam int LOG2N    = $clog2(NUM_PORTS),
  localparam int BUS_W    = NUM_PORTS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  slotCtrl_t            ctrl,
  input  logic [BUS_W-1:0]     inData,
  input  logic [NUM_PORTS-1:0] inValid,
  output logic [BUS_W-1:0]     outData,
  output logic [NUM_PORTS-1:0] outValid
);

  logic [BUS_W-1:0]     stgData  [0:LOG2N];
  logic [NUM_PORTS-1:0] stgValid [0:LOG2N];

  assign stgData[0]  = inData;
  assign stgValid[0] = inValid;

  for (genvar s = 0; s < LOG2N; s++) begin : g_stage
    tdm_exchange_stage #(
      .NUM_PORTS (NUM_PORTS),
      .DATA_W    (DATA_W),
      .PAIR_BIT  (s)
    ) u_stage (
      .crossEn  (ctrl.crossEn[s]),
      .inData   (stgData[s]),
      .inValid  (stgValid[s]),
      .outData  (stgData[s+1]),
      .outValid (stgValid[s+1])
    );
  end

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= '0;
      armed    <= 1'b0;
    end else begin
      outData  <= stgData[LOG2N];
      outValid <= stgValid[LOG2N];
      armed    <= 1'b1;
    end
  end

  // R3: stages beyond the fabric depth never receive a cross request
  a_r3_spare_bits_bar: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.crossEn >> LOG2N) == '0);

  // R8: the frame-start slot applies the all-bar control
  a_r8_frame_start_bar: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.frameStart |-> (ctrl.crossEn == '0));

  // R8: slot 0 passes every word straight through
  a_r8_identity: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(ctrl.frameStart)) |-> (outData == $past(inData) && outValid == $past(inValid)));

  // R7: a permutation neither drops nor duplicates valid words
  a_r7_valid_count: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ($countones(outValid) == $past($countones(inValid))));

endmodule

// File: rtl/tdm_banyan_fabric.sv
module tdm_banyan_fabric
  import tdm_fabric_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int DATA_W    = 8,
  localparam int LOG2N    = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS*DATA_W-1:0] inData,
  input  logic [NUM_PORTS-1:0]        inValid,
  output logic [NUM_PORTS*DATA_W-1:0] outData,
  output logic [NUM_PORTS-1:0]        outValid,
  output logic [LOG2N-1:0]            ctrlWord,
  output logic [LOG2N-1:0]            slotIdx
);

  initial begin
    if ((1 << LOG2N) != NUM_PORTS || LOG2N < 1 || LOG2N > MAX_STAGES)
      $error("NUM_PORTS must be a power of two between 2 and 2**MAX_STAGES");
  end

  slotCtrl_t ctrl;

  tdm_slot_ctrl #(
    .NUM_PORTS (NUM_PORTS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .slotIdx (slotIdx)
  );

  tdm_banyan_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .inData   (inData),
    .inValid  (inValid),
    .outData  (outData),
    .outValid (outValid)
  );

  assign ctrlWord = ctrl.crossEn[LOG2N-1:0];

endmodule

// File: tb/tdm_banyan_fabric_tb.sv
module tdm_banyan_fabric_tb;

  localparam int N          = 16;
  localparam int W          = 8;
  localparam int LG         = 4;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES     = 6;

  logic           clk = 1'b0;
  logic           rstN;
  logic [N*W-1:0] inData;
  logic [N-1:0]   inValid;
  logic [N*W-1:0] outData;
  logic [N-1:0]   outValid;
  logic [LG-1:0]  ctrlWord;
  logic [LG-1:0]  slotIdx;

  int errors = 0;
  int checks = 0;
  int seen [N][N];

  logic [N*W-1:0] prevData;
  logic [N-1:0]   prevValid;
  int             prevSlot;
  bit             havePrev;
  bit             finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_banyan_fabric #(.NUM_PORTS(N), .DATA_W(W)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inValid  (inValid),
    .outData  (outData),
    .outValid (outValid),
    .ctrlWord (ctrlWord),
    .slotIdx  (slotIdx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic validFor(input int frame, input int i, input int t);
    case (frame)
      2:       return ((i + t) % 3) != 0;
      3:       return (i % 2) == 1;
      4:       return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) seen[a][b] = 0;
    rstN     = 1'b0;
    inValid  = '1;
    for (int i = 0; i < N; i++) inData[i*W +: W] = W'(8'hA0 + i);
    havePrev = 0;
    prevSlot = 0;
    prevData = '0;
    prevValid = '0;

    repeat (3) @(negedge clk);
    // R1: reset state with active inputs
    check(outValid == '0, "R1 outValid in reset", int'(outValid), 0);
    check(outData == '0, "R1 outData in reset", int'(outData[31:0]), 0);
    check(slotIdx == '0, "R1 slotIdx in reset", int'(slotIdx), 0);
    rstN = 1'b1;

    for (int step = 0; step <= N*FRAMES; step++) begin
      if (step > 0) @(negedge clk);
      if (havePrev) begin
        int srcMask;
        srcMask = 0;
        for (int j = 0; j < N; j++) begin
          int src;
          int tag;
          src = j ^ prevSlot;
          // R4: word from input j^t lands on output j
          check(outData[j*W +: W] == prevData[src*W +: W], "R4 routed data",
                int'(outData[j*W +: W]), int'(prevData[src*W +: W]));
          // R5: valid travels with its word
          check(outValid[j] == prevValid[src], "R5 routed valid",
                int'(outValid[j]), int'(prevValid[src]));
          tag = int'(outData[j*W +: 4]);
          seen[tag][j]++;
          srcMask |= (1 << tag);
        end
        // R7: every source appears exactly once in this slot
        check(srcMask == (1 << N) - 1, "R7 one output per input", srcMask, (1 << N) - 1);
        if (prevSlot == 0)  // R8: slot 0 is the identity
          check(outData == prevData, "R8 identity in slot 0",
                int'(outData[31:0]), int'(prevData[31:0]));
        if (prevSlot == N-1) begin
          // R6: full access over the frame just finished
          for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++) begin
              check(seen[a][b] == 1, "R6 pair count per frame", seen[a][b], 1);
              seen[a][b] = 0;
            end
        end
      end
      // R2: slot index follows the cycle count modulo N
      check(int'(slotIdx) == step % N, "R2 slot index", int'(slotIdx), step % N);
      // R3: control word mirrors the slot index
      check(int'(ctrlWord) == step % N, "R3 control word", int'(ctrlWord), step % N);
      for (int i = 0; i < N; i++) begin
        inData[i*W +: W] = {4'((step * 5 + i * 3) & 15), 4'(i)};
        inValid[i]       = validFor(step / N, i, step % N);
      end
      prevData  = inData;
      prevValid = inValid;
      prevSlot  = step % N;
      havePrev  = 1;
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule